// File: doc/BRIEF.md
# SPI Command Decoder with Register and Memory Strobes

This block is an SPI target that turns byte streams from a host controller into configuration register updates and memory accesses. The SPI pins are brought into the system clock domain through synchronizers. A byte shifter assembles received bytes and shifts reply bytes back out. A command engine, built around a single state machine, interprets each frame. A frame begins when chip-select goes low. Its first byte is a command: the upper nibble picks a command family and the lower nibble carries that family's parameter.

The engine holds three address pointers (a main RAM pointer and two buffer pointers), two address masks, a mapper code, a feature-enable register and an 8-bit status register that is changed through set and reset masks. The external memory is represented only by read and write strobes, an address bus and a read-data input. Read data must be returned on the cycle after the read strobe. Replies are pipelined by one byte: the byte shifted out while byte N+1 is clocked in is the reply to byte N.

Engine states: `ST_CMD` (wait for command), `ST_PTR` (collect pointer bytes), `ST_MASK` (collect mask bytes), `ST_READ` (memory read stream), `ST_WRITE` (memory write stream), `ST_SETM` (status set mask), `ST_CLRM` (status reset mask), `ST_FEAT` (feature byte), `ST_STAT` (status word readback), `ST_ECHO` (echo stream) and `ST_SKIP` (ignore until end of frame).

Transitions:
- `ST_CMD` leaves on the command byte according to the family decode.
- `ST_PTR` and `ST_MASK` go to `ST_SKIP` on their last byte.
- `ST_SETM` goes to `ST_CLRM`.
- `ST_CLRM` and `ST_FEAT` go to `ST_SKIP`.
- `ST_READ`, `ST_WRITE`, `ST_STAT`, `ST_ECHO` and `ST_SKIP` stay in place for the rest of the frame.
- From any state, chip-select high returns the engine to `ST_CMD`.

Top module: `spi_cmd_decoder`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is sampled on the SCK rising edge and MISO changes on the falling edge. The first byte after chip-select falls is the command, with bits 7:4 as the family and bits 3:0 as the parameter. The byte on MISO during byte N+1 is the reply to byte N, and the reply shifted during the first byte is 0x00.
- R2: Command 0x0t loads a pointer for target t. t=0 loads the 24-bit RAM pointer from three bytes. t=1 loads the 16-bit audio-buffer pointer and t=2 the 16-bit data-buffer pointer, each from two bytes. Bytes arrive MSB first, and the pointer is written only when its last byte arrives. t=3..15 is ignored.
- R3: Family 0x1 loads the 24-bit input-address mask and family 0x2 the 24-bit save-RAM mask. Each takes three bytes, MSB first, and the mask is written on the last byte.
- R4: Command 0x3m stores the 4-bit mapper code m immediately. No further bytes are used.
- R5: Command 0x8p reads main memory at the RAM pointer. The reply to the command byte and to each later byte is the memory byte at the current pointer. If p bit 3 is set, the pointer increments each time a later byte completes. A frame with only the command byte leaves the pointer unchanged.
- R6: Command 0x9p writes each later byte to target p[1:0] (0 RAM, 1 audio buffer, 2 data buffer), at that target's pointer zero-extended to 24 bits. If p bit 3 is set, that pointer increments after each write. Target 3 issues no write strobe. Read and write strobes never coincide.
- R7: Command 0xE0 takes a set mask and then a reset mask. The status register becomes (old OR set) AND NOT reset, so reset wins where both masks have the bit. Status changes only at byte boundaries.
- R8: Command 0xED loads the feature register from one byte. Bits 4:0 are kept and bits 7:5 read as zero.
- R9: Command 0xF1 returns the 16-bit word {dma_busy, 7'b0, status[7:0]}, high byte first. Further bytes keep alternating high and low bytes.
- R10: Command 0xF0 replies with the token 0xA5. Later bytes in the frame reply 0x00.
- R11: Command 0xFF echoes: the reply to each byte after the command is that same byte, and the reply to the command byte is 0x00.
- R12: Chip-select high aborts any partial command and returns the engine to `ST_CMD`. A pointer or mask whose bytes were not all received keeps its previous value.
- R13: Any other command (families 0x4-0x7 and 0xA-0xD, 0xE1-0xEC and 0xEE-0xEF, 0xF2-0xFE) changes no register, issues no strobe and replies 0x00 for the rest of the frame. A later byte in that frame is never treated as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| dma_busy | input | 1 | Busy flag reported in status word bit 15 |
| mem_rd_data | input | 8 | Read data, valid the cycle after mem_rd_stb |
| mem_addr | output | 24 | Memory address for the current strobe |
| mem_wr_stb | output | 1 | One-cycle write strobe |
| mem_rd_stb | output | 1 | One-cycle read strobe (main RAM) |
| mem_wr_data | output | 8 | Write data |
| mem_wr_tgt | output | 2 | Write target: 0 RAM, 1 audio, 2 data |
| ram_ptr | output | 24 | Main RAM address pointer |
| aud_ptr | output | 16 | Audio-buffer pointer |
| dat_ptr | output | 16 | Data-buffer pointer |
| in_mask | output | 24 | Input address mask |
| save_mask | output | 24 | Save-RAM address mask |
| mapper | output | 4 | Mapper code |
| features | output | 8 | Feature-enable bits |
| status | output | 8 | Set/reset status register |

## Verification
The assertions check on every cycle that:
- read and write strobes never overlap;
- the read address equals the RAM pointer;
- the mapper, status and RAM pointer move only on the cycle after a completed byte;
- the engine is back in `ST_CMD` after any cycle with chip-select high.

Only the bench scenarios can show that the values are correct. These include the MSB-first assembly of pointers and masks, the reset-wins status arithmetic, and the one-byte reply latency for reads, token, status and echo. They also include the effect of an abort on partial loads, and the fact that a byte after an ignored command is not decoded.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_PTR,
        ST_MASK,
        ST_READ,
        ST_WRITE,
        ST_SETM,
        ST_CLRM,
        ST_FEAT,
        ST_STAT,
        ST_ECHO,
        ST_SKIP
    } cmd_state_e;

    // command families (upper nibble of the command byte)
    localparam logic [3:0] FAM_PTR   = 4'h0;
    localparam logic [3:0] FAM_IMASK = 4'h1;
    localparam logic [3:0] FAM_SMASK = 4'h2;
    localparam logic [3:0] FAM_MAP   = 4'h3;
    localparam logic [3:0] FAM_READ  = 4'h8;
    localparam logic [3:0] FAM_WRITE = 4'h9;
    localparam logic [3:0] FAM_EXT   = 4'hE;
    localparam logic [3:0] FAM_QUERY = 4'hF;

    // sub-codes inside the extended and query families
    localparam logic [3:0] EXT_STATUS = 4'h0;
    localparam logic [3:0] EXT_FEAT   = 4'hD;
    localparam logic [3:0] QRY_TOKEN  = 4'h0;
    localparam logic [3:0] QRY_STATUS = 4'h1;
    localparam logic [3:0] QRY_ECHO   = 4'hF;

endpackage

// File: rtl/spi_sync_bit.sv
module spi_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       cs_active
);
    localparam int          NSIG     = 3;
    localparam logic [NSIG-1:0] SYNC_RST = 3'b010; // cs_n idles high

    logic [NSIG-1:0] raw_in, syn_in;
    assign raw_in = {mosi, cs_n, sck};

    for (genvar i = 0; i < NSIG; i++) begin : g_sync
        spi_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_in[i]),
            .q    (syn_in[i])
        );
    end

    logic sck_s, cs_n_s, mosi_s;
    assign sck_s  = syn_in[0];
    assign cs_n_s = syn_in[1];
    assign mosi_s = syn_in[2];

    logic       sck_prev_q;
    logic [2:0] bit_cnt_q;
    logic [6:0] rx_sh_q;
    logic [7:0] rx_byte_q;
    logic [7:0] tx_sh_q;
    logic       rx_valid_q;
    logic       sck_rise, sck_fall;

    assign cs_active = ~cs_n_s;
    assign sck_rise  = sck_s & ~sck_prev_q;
    assign sck_fall  = ~sck_s & sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            rx_byte_q  <= '0;
            tx_sh_q    <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            rx_valid_q <= 1'b0;
            if (!cs_active) begin
                bit_cnt_q <= '0;
                tx_sh_q   <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh_q   <= {rx_sh_q[5:0], mosi_s};
                    bit_cnt_q <= bit_cnt_q + 3'd1;
                    if (bit_cnt_q == 3'd7) begin
                        rx_valid_q <= 1'b1;
                        rx_byte_q  <= {rx_sh_q, mosi_s};
                    end
                end
                if (sck_fall) begin
                    // byte boundary: present the reply prepared for the last byte
                    if (bit_cnt_q == 3'd0) tx_sh_q <= tx_byte;
                    else                   tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign miso     = tx_sh_q[7];
    assign rx_valid = rx_valid_q;
    assign rx_byte  = rx_byte_q;

    // R1
    rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cs_active));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int         ADDR_W = 24,
    parameter int         BUF_W  = 16,
    parameter int         FEAT_W = 5,
    parameter logic [7:0] TOKEN  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              dma_busy,
    input  logic [7:0]        mem_rd_data,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_stb,
    output logic              mem_rd_stb,
    output logic [7:0]        mem_wr_data,
    output logic [1:0]        mem_wr_tgt,
    output logic [ADDR_W-1:0] ram_ptr,
    output logic [BUF_W-1:0]  aud_ptr,
    output logic [BUF_W-1:0]  dat_ptr,
    output logic [ADDR_W-1:0] in_mask,
    output logic [ADDR_W-1:0] save_mask,
    output logic [3:0]        mapper,
    output logic [7:0]        features,
    output logic [7:0]        status
);
    localparam int         ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int         BUF_BYTES  = (BUF_W + 7) / 8;
    localparam int         CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [7:0] FEAT_MASK  = 8'((1 << FEAT_W) - 1);

    cmd_state_e state_q, state_d;

    logic [CNT_W-1:0]  cnt_q, need_q;
    logic [ADDR_W-9:0] asm_q;
    logic [1:0]        tgt_q;
    logic              inc_q;
    logic              mask_sel_q;
    logic [7:0]        set_q;
    logic              half_q;
    logic              rd_req_q, rd_cap_q;
    logic [7:0]        tx_q;
    logic              last_byte;

    assign last_byte = (CNT_W'(cnt_q + 1'b1) == need_q);

    // ---------------- next-state decode ----------------
    always_comb begin
        state_d = state_q;
        if (!cs_active) begin
            state_d = ST_CMD;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_CMD: begin
                    case (rx_byte[7:4])
                        FAM_PTR:   state_d = (rx_byte[3:0] <= 4'd2) ? ST_PTR : ST_SKIP;
                        FAM_IMASK,
                        FAM_SMASK: state_d = ST_MASK;
                        FAM_READ:  state_d = ST_READ;
                        FAM_WRITE: state_d = ST_WRITE;
                        FAM_EXT: begin
                            if (rx_byte[3:0] == EXT_STATUS)    state_d = ST_SETM;
                            else if (rx_byte[3:0] == EXT_FEAT) state_d = ST_FEAT;
                            else                               state_d = ST_SKIP;
                        end
                        FAM_QUERY: begin
                            if (rx_byte[3:0] == QRY_STATUS)    state_d = ST_STAT;
                            else if (rx_byte[3:0] == QRY_ECHO) state_d = ST_ECHO;
                            else                               state_d = ST_SKIP;
                        end
                        default:   state_d = ST_SKIP;
                    endcase
                end
                ST_PTR, ST_MASK: if (last_byte) state_d = ST_SKIP;
                ST_SETM:         state_d = ST_CLRM;
                ST_CLRM,
                ST_FEAT:         state_d = ST_SKIP;
                ST_READ, ST_WRITE, ST_STAT, ST_ECHO, ST_SKIP: state_d = state_q;
                default:         state_d = ST_CMD;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // ---------------- outputs and registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            need_q      <= '0;
            asm_q       <= '0;
            tgt_q       <= '0;
            inc_q       <= 1'b0;
            mask_sel_q  <= 1'b0;
            set_q       <= '0;
            half_q      <= 1'b0;
            rd_req_q    <= 1'b0;
            rd_cap_q    <= 1'b0;
            tx_q        <= '0;
            mem_addr    <= '0;
            mem_wr_stb  <= 1'b0;
            mem_rd_stb  <= 1'b0;
            mem_wr_data <= '0;
            mem_wr_tgt  <= '0;
            ram_ptr     <= '0;
            aud_ptr     <= '0;
            dat_ptr     <= '0;
            in_mask     <= '0;
            save_mask   <= '0;
            mapper      <= '0;
            features    <= '0;
            status      <= '0;
        end else begin
            mem_wr_stb <= 1'b0;
            mem_rd_stb <= rd_req_q;
            rd_req_q   <= 1'b0;
            rd_cap_q   <= mem_rd_stb;
            if (rd_req_q) mem_addr <= ram_ptr;

            if (!cs_active) begin
                cnt_q    <= '0;
                tx_q     <= '0;
                rd_req_q <= 1'b0;
            end else if (rx_valid) begin
                tx_q <= '0;
                unique case (state_q)
                    ST_CMD: begin
                        cnt_q      <= '0;
                        tgt_q      <= rx_byte[1:0];
                        inc_q      <= rx_byte[3];
                        mask_sel_q <= (rx_byte[7:4] == FAM_SMASK);
                        need_q     <= (rx_byte[7:4] == FAM_PTR && rx_byte[3:0] != 4'd0)
                                      ? CNT_W'(BUF_BYTES) : CNT_W'(ADDR_BYTES);
                        case (rx_byte[7:4])
                            FAM_MAP:   mapper   <= rx_byte[3:0];
                            FAM_READ:  rd_req_q <= 1'b1;
                            FAM_QUERY: begin
                                if (rx_byte[3:0] == QRY_TOKEN)  tx_q <= TOKEN;
                                if (rx_byte[3:0] == QRY_STATUS) begin
                                    tx_q   <= {dma_busy, 7'b0};
                                    half_q <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                    ST_PTR: begin
                        cnt_q <= cnt_q + 1'b1;
                        asm_q <= {asm_q[ADDR_W-17:0], rx_byte};
                        if (last_byte) begin
                            case (tgt_q)
                                2'd0:    ram_ptr <= {asm_q, rx_byte};
                                2'd1:    aud_ptr <= {asm_q[BUF_W-9:0], rx_byte};
                                default: dat_ptr <= {asm_q[BUF_W-9:0], rx_byte};
                            endcase
                        end
                    end
                    ST_MASK: begin
                        cnt_q <= cnt_q + 1'b1;
                        asm_q <= {asm_q[ADDR_W-17:0], rx_byte};
                        if (last_byte) begin
                            if (mask_sel_q) save_mask <= {asm_q, rx_byte};
                            else            in_mask   <= {asm_q, rx_byte};
                        end
                    end
                    ST_READ: begin
                        if (inc_q) ram_ptr <= ram_ptr + 1'b1;
                        rd_req_q <= 1'b1;
                    end
                    ST_WRITE: begin
                        if (tgt_q != 2'd3) begin
                            mem_wr_stb  <= 1'b1;
                            mem_wr_data <= rx_byte;
                            mem_wr_tgt  <= tgt_q;
                        end
                        case (tgt_q)
                            2'd0: begin
                                mem_addr <= ram_ptr;
                                if (inc_q) ram_ptr <= ram_ptr + 1'b1;
                            end
                            2'd1: begin
                                mem_addr <= ADDR_W'(aud_ptr);
                                if (inc_q) aud_ptr <= aud_ptr + 1'b1;
                            end
                            2'd2: begin
                                mem_addr <= ADDR_W'(dat_ptr);
                                if (inc_q) dat_ptr <= dat_ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    ST_SETM: set_q    <= rx_byte;
                    ST_CLRM: status   <= (status | set_q) & ~rx_byte;
                    ST_FEAT: features <= rx_byte & FEAT_MASK;
                    ST_STAT: begin
                        tx_q   <= half_q ? status : {dma_busy, 7'b0};
                        half_q <= ~half_q;
                    end
                    ST_ECHO: tx_q <= rx_byte;
                    ST_SKIP: ;
                    default: ;
                endcase
            end else if (rd_cap_q) begin
                tx_q <= mem_rd_data;
            end
        end
    end

    assign tx_byte = tx_q;

    // ---------------- assertions ----------------
    // R6
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_stb && mem_rd_stb));

    // R6
    wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_stb |-> $past(rx_valid));

    // R5
    rd_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_stb |-> (mem_addr == ram_ptr));

    // R4
    mapper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(mapper));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(status));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> $stable(ram_ptr));

    // R12
    abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_active) |-> (state_q == ST_CMD));
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
    parameter int         ADDR_W      = 24,
    parameter int         BUF_W       = 16,
    parameter int         FEAT_W      = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] TOKEN       = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              dma_busy,
    input  logic [7:0]        mem_rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_stb,
    output logic              mem_rd_stb,
    output logic [7:0]        mem_wr_data,
    output logic [1:0]        mem_wr_tgt,
    output logic [ADDR_W-1:0] ram_ptr,
    output logic [BUF_W-1:0]  aud_ptr,
    output logic [BUF_W-1:0]  dat_ptr,
    output logic [ADDR_W-1:0] in_mask,
    output logic [ADDR_W-1:0] save_mask,
    output logic [3:0]        mapper,
    output logic [7:0]        features,
    output logic [7:0]        status
);
    logic       rx_valid, cs_active;
    logic [7:0] rx_byte, tx_byte;

    spi_byte_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cs_active(cs_active)
    );

    spi_cmd_engine #(
        .ADDR_W(ADDR_W),
        .BUF_W (BUF_W),
        .FEAT_W(FEAT_W),
        .TOKEN (TOKEN)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .dma_busy   (dma_busy),
        .mem_rd_data(mem_rd_data),
        .tx_byte    (tx_byte),
        .mem_addr   (mem_addr),
        .mem_wr_stb (mem_wr_stb),
        .mem_rd_stb (mem_rd_stb),
        .mem_wr_data(mem_wr_data),
        .mem_wr_tgt (mem_wr_tgt),
        .ram_ptr    (ram_ptr),
        .aud_ptr    (aud_ptr),
        .dat_ptr    (dat_ptr),
        .in_mask    (in_mask),
        .save_mask  (save_mask),
        .mapper     (mapper),
        .features   (features),
        .status     (status)
    );
endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;   // system clocks per SCK half period
    localparam int NV         = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic        dma_busy = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [23:0] mem_addr;
    logic        wr_stb, rd_stb;
    logic [7:0]  wr_data;
    logic [1:0]  wr_tgt;
    logic [23:0] ram_ptr, in_mask, save_mask;
    logic [15:0] aud_ptr, dat_ptr;
    logic [3:0]  mapper;
    logic [7:0]  features, status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_decoder u_spi_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dma_busy(dma_busy), .mem_rd_data(rd_data),
        .mem_addr(mem_addr), .mem_wr_stb(wr_stb), .mem_rd_stb(rd_stb),
        .mem_wr_data(wr_data), .mem_wr_tgt(wr_tgt), .ram_ptr(ram_ptr),
        .aud_ptr(aud_ptr), .dat_ptr(dat_ptr), .in_mask(in_mask),
        .save_mask(save_mask), .mapper(mapper), .features(features), .status(status)
    );

    // memory model: read data one cycle after strobe, RAM writes stored
    logic [7:0]  mem [256];
    int          wr_count = 0;
    logic [23:0] last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [1:0]  last_tgt  = '0;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(posedge clk) begin
        if (rd_stb) rd_data <= mem[mem_addr[7:0]];
        if (wr_stb) begin
            wr_count  <= wr_count + 1;
            last_addr <= mem_addr;
            last_data <= wr_data;
            last_tgt  <= wr_tgt;
            if (wr_tgt == 2'd0) mem[mem_addr[7:0]] <= wr_data;
        end
    end

    // {req[4], len[3], bytes[32], sel[3], expected[24]}
    localparam logic [65:0] VEC [NV] = '{
        {4'd2,  3'd4, 32'h00010203, 3'd0, 24'h010203},  // R2 RAM pointer
        {4'd2,  3'd3, 32'h01ABCD00, 3'd1, 24'h00ABCD},  // R2 audio pointer
        {4'd2,  3'd3, 32'h02123400, 3'd2, 24'h001234},  // R2 data pointer
        {4'd2,  3'd4, 32'h03778899, 3'd0, 24'h010203},  // R2 target 3 ignored
        {4'd3,  3'd4, 32'h10FF000F, 3'd3, 24'hFF000F},  // R3 input mask
        {4'd3,  3'd4, 32'h20007FFF, 3'd4, 24'h007FFF},  // R3 save mask
        {4'd4,  3'd1, 32'h36000000, 3'd5, 24'h000006},  // R4 mapper 6
        {4'd4,  3'd1, 32'h3F000000, 3'd5, 24'h00000F},  // R4 mapper F
        {4'd7,  3'd3, 32'hE0F00F00, 3'd7, 24'h0000F0},  // R7 set/reset
        {4'd7,  3'd3, 32'hE0033000, 3'd7, 24'h0000C3},  // R7
        {4'd7,  3'd3, 32'hE0010100, 3'd7, 24'h0000C2},  // R7 reset wins
        {4'd8,  3'd2, 32'hEDFF0000, 3'd6, 24'h00001F},  // R8 upper bits zero
        {4'd13, 3'd2, 32'h5A310000, 3'd5, 24'h00000F},  // R13 byte after unknown cmd not decoded
        {4'd4,  3'd1, 32'h37000000, 3'd5, 24'h000007},  // R4 mapper 7
        {4'd13, 3'd2, 32'h4C360000, 3'd5, 24'h000007}   // R13
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_stop();
        tick(HALF);
        cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    function automatic logic [23:0] pick(input logic [2:0] sel);
        case (sel)
            3'd0: return ram_ptr;
            3'd1: return {8'h0, aud_ptr};
            3'd2: return {8'h0, dat_ptr};
            3'd3: return in_mask;
            3'd4: return save_mask;
            3'd5: return {20'h0, mapper};
            3'd6: return {16'h0, features};
            default: return {16'h0, status};
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r0, r1, r2, r3;
        int wc;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // reset state
        check("R1 reset miso", {31'b0, miso}, 32'h0);
        check("R2 reset ram_ptr", {8'h0, ram_ptr}, 32'h0);
        check("R7 reset status", {24'h0, status}, 32'h0);
        check("R6 reset strobes", {30'b0, wr_stb, rd_stb}, 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [2:0] len;
            len = VEC[k][61:59];
            frame_start();
            for (int b = 0; b < int'(len); b++) xfer(VEC[k][58-8*b -: 8], r0);
            frame_stop();
            check($sformatf("R%0d vector %0d", VEC[k][65:62], k),
                  {8'h0, pick(VEC[k][26:24])}, {8'h0, VEC[k][23:0]});
        end

        // R10 token, R1 first reply zero
        frame_start(); xfer(8'hF0, r0); xfer(8'h00, r1); xfer(8'h00, r2); frame_stop();
        check("R1 first reply", {24'h0, r0}, 32'h0);
        check("R10 token", {24'h0, r1}, 32'hA5);
        check("R10 after token", {24'h0, r2}, 32'h0);

        // R6 write with increment to RAM
        frame_start(); xfer(8'h00, r0); xfer(8'h00, r0); xfer(8'h01, r0); xfer(8'h00, r0); frame_stop();
        wc = wr_count;
        frame_start(); xfer(8'h98, r0); xfer(8'hAA, r0); xfer(8'hBB, r0); frame_stop();
        check("R6 write count", wr_count - wc, 2);
        check("R6 last addr", {8'h0, last_addr}, 32'h000101);
        check("R6 last data", {24'h0, last_data}, 32'hBB);
        check("R6 first byte stored", {24'h0, mem[8'h00]}, 32'hAA);
        check("R6 ram_ptr after", {8'h0, ram_ptr}, 32'h000102);

        // R5 read with increment
        frame_start(); xfer(8'h00, r0); xfer(8'h00, r0); xfer(8'h01, r0); xfer(8'h00, r0); frame_stop();
        frame_start(); xfer(8'h88, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); frame_stop();
        check("R5 read byte0", {24'h0, r1}, 32'hAA);
        check("R5 read byte1", {24'h0, r2}, 32'hBB);
        check("R5 read byte2", {24'h0, r3}, 32'h58);
        check("R5 ptr after inc read", {8'h0, ram_ptr}, 32'h000103);

        // R5 read without increment
        frame_start(); xfer(8'h80, r0); xfer(8'h00, r1); xfer(8'h00, r2); frame_stop();
        check("R5 noinc byte0", {24'h0, r1}, 32'h59);
        check("R5 noinc byte1", {24'h0, r2}, 32'h59);
        check("R5 noinc ptr", {8'h0, ram_ptr}, 32'h000103);

        // R5 empty read has no side effect
        frame_start(); xfer(8'h88, r0); frame_stop();
        check("R5 empty read ptr", {8'h0, ram_ptr}, 32'h000103);

        // R6 audio target
        frame_start(); xfer(8'h01, r0); xfer(8'h12, r0); xfer(8'h34, r0); frame_stop();
        frame_start(); xfer(8'h99, r0); xfer(8'h11, r0); frame_stop();
        check("R6 audio tgt", {30'h0, last_tgt}, 32'h1);
        check("R6 audio addr", {8'h0, last_addr}, 32'h001234);
        check("R6 audio ptr inc", {16'h0, aud_ptr}, 32'h1235);
        wc = wr_count;
        frame_start(); xfer(8'h91, r0); xfer(8'h22, r0); xfer(8'h33, r0); frame_stop();
        check("R6 noinc count", wr_count - wc, 2);
        check("R6 noinc data", {24'h0, last_data}, 32'h33);
        check("R6 noinc ptr", {16'h0, aud_ptr}, 32'h1235);
        wc = wr_count;
        frame_start(); xfer(8'h9B, r0); xfer(8'h22, r0); frame_stop();
        check("R6 target3 no strobe", wr_count - wc, 0);

        // R9 status word
        dma_busy = 1'b1;
        frame_start(); xfer(8'hF1, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); frame_stop();
        check("R9 status hi busy", {24'h0, r1}, 32'h80);
        check("R9 status lo", {24'h0, r2}, 32'hC2);
        check("R9 status alternates", {24'h0, r3}, 32'h80);
        dma_busy = 1'b0;
        frame_start(); xfer(8'hF1, r0); xfer(8'h00, r1); frame_stop();
        check("R9 status hi idle", {24'h0, r1}, 32'h00);

        // R11 echo
        frame_start(); xfer(8'hFF, r0); xfer(8'h3C, r1); xfer(8'hC3, r2); xfer(8'h00, r3); frame_stop();
        check("R11 echo cmd reply", {24'h0, r1}, 32'h00);
        check("R11 echo 1", {24'h0, r2}, 32'h3C);
        check("R11 echo 2", {24'h0, r3}, 32'hC3);

        // R12 abort
        frame_start(); xfer(8'h10, r0); xfer(8'h12, r0); xfer(8'h34, r0); frame_stop();
        check("R12 partial mask kept", {8'h0, in_mask}, 32'hFF000F);
        frame_start(); xfer(8'h00, r0); xfer(8'h55, r0); frame_stop();
        check("R12 partial ptr kept", {8'h0, ram_ptr}, 32'h000103);
        frame_start(); xfer(8'h31, r0); frame_stop();
        check("R12 next frame is command", {28'h0, mapper}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule